// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address sequence for a four-beat burst on a synchronous burst memory. A burst starts when either of two start strobes is sampled high, one driven from the processor side and one from the cache-controller side. The block then holds a full address made of the loaded upper bits and a two-bit beat offset. Each cycle in which the advance input is sampled high and no strobe is sampled high moves the burst to the next beat. After the fourth beat the sequence wraps back to the starting address.

The order of the beats comes from an ordering-select input, which is captured when a burst is loaded. Low selects linear order: the low two bits count up from the start value, modulo 4. High selects interleaved order: the low two bits are the start value XOR the beat number. An unconnected select pin is treated as high, so the register that holds the order resets to interleaved. The block also reports the current beat number, a flag for the first beat and a flag for the last beat. All inputs are sampled on the rising clock edge. Every output comes straight from registers through a small combinational mapping.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it returns high with no input activity, `addr_out` is 0 and `beat_idx` is 0; `burst_first` is 1 and `burst_last` is 0.
- R2: If `strobe_cpu` or `strobe_ctl` is high at a rising edge, then after that edge `addr_out` equals the `load_addr` sampled at that edge and `beat_idx` is 0. Either strobe alone has this effect, and so do both together.
- R3: If `advance` is high at a rising edge and neither strobe is high, `beat_idx` increases by one, modulo 4.
- R4: When the ordering select captured at load was 0 (linear), bits [1:0] of `addr_out` equal (start low bits + `beat_idx`) mod 4.
- R5: When the ordering select captured at load was 1 (interleaved), bits [1:0] of `addr_out` equal the start low bits XOR `beat_idx`.
- R6: A strobe sampled together with `advance` reloads the address and restarts at beat 0, and the advance is ignored.
- R7: If no strobe and no `advance` are high at an edge, `addr_out` and `beat_idx` do not change, whatever `load_addr` or `order_sel` do.
- R8: Bits above bit 1 of `addr_out` keep the loaded value for the whole burst.
- R9: The ordering select is captured only at a load. Changing it during a burst does not alter the remaining beats.
- R10: An advance out of beat 3 wraps the burst to beat 0, so `addr_out` returns to the start address.
- R11: `burst_first` is 1 exactly when `beat_idx` is 0, and `burst_last` is 1 exactly when `beat_idx` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_cpu | input | 1 | Processor-side burst start strobe |
| strobe_ctl | input | 1 | Cache-controller-side burst start strobe |
| advance | input | 1 | Step to the next beat |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved; captured at load |
| load_addr | input | ADDR_W | Starting address of a burst |
| addr_out | output | ADDR_W | Current burst address |
| beat_idx | output | 2 | Current beat number, 0 to 3 |
| burst_first | output | 1 | High on beat 0 |
| burst_last | output | 1 | High on beat 3 |

## Verification
The properties assume that the strobes and `advance` are free-running levels that are valid at every rising edge, with no requirement that a strobe be followed by advances. They also assume that `load_addr` and `order_sel` matter only at a load edge. The properties are checked only while `rst_n` is high, and the bench pulses reset only between edges on a falling clock. Every input changes on the falling edge, so the stimulus never sits near the sampling edge. The stimulus covers every combination that the properties single out: strobes alone or together, a strobe with `advance`, `advance` alone, and idle.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

  // Width of the beat counter; a burst covers 2**BEAT_W addresses.
  localparam int BEAT_W = 2;
  localparam int BEATS  = 1 << BEAT_W;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Linear order: the offset counts up from the start value and wraps.
  function automatic beat_t lin_offset(beat_t start, beat_t beat);
    return beat_t'(start + beat);
  endfunction

  // Interleaved order: each beat number toggles bits of the start value.
  function automatic beat_t ilv_offset(beat_t start, beat_t beat);
    return start ^ beat;
  endfunction

  function automatic beat_t map_offset(order_e ord, beat_t start, beat_t beat);
    return (ord == ORD_LINEAR) ? lin_offset(start, beat) : ilv_offset(start, beat);
  endfunction

endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode (
  input  logic strobe_cpu,
  input  logic strobe_ctl,
  input  logic advance,
  output logic load_evt,
  output logic step_evt
);
  // A strobe on either side starts a burst and masks any advance.
  always_comb begin
    load_evt = strobe_cpu | strobe_ctl;
    step_evt = advance & ~load_evt;
  end
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20,
  localparam int HI_W  = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              order_sel,
  output logic [HI_W-1:0]   hi_q,
  output beat_t             start_q,
  output order_e            order_q
);
  // The reset value of the order register is interleaved, which matches an
  // unconnected select pin.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      start_q <= '0;
      order_q <= ORD_INTERLEAVE;
    end else if (load_evt) begin
      hi_q    <= load_addr[ADDR_W-1:BEAT_W];
      start_q <= load_addr[BEAT_W-1:0];
      order_q <= order_e'(order_sel);
    end
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_addr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_evt,
  input  logic  step_evt,
  output beat_t beat_q,
  output logic  at_first,
  output logic  at_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat_q <= '0;
    else if (load_evt) beat_q <= '0;
    else if (step_evt) beat_q <= beat_t'(beat_q + 1'b1);
  end

  always_comb begin
    at_first = (beat_q == '0);
    at_last  = (beat_q == beat_t'(BEATS - 1));
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_addr_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_cpu,
  input  logic              strobe_ctl,
  input  logic              advance,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] load_addr,
  output logic [ADDR_W-1:0] addr_out,
  output logic [1:0]        beat_idx,
  output logic              burst_first,
  output logic              burst_last
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic            load_evt;
  logic            step_evt;
  logic [HI_W-1:0] hi_q;
  beat_t           start_q;
  order_e          order_q;
  beat_t           beat_q;
  beat_t           offset;

  burst_cmd_decode u_dec (
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .advance    (advance),
    .load_evt   (load_evt),
    .step_evt   (step_evt)
  );

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .load_addr (load_addr),
    .order_sel (order_sel),
    .hi_q      (hi_q),
    .start_q   (start_q),
    .order_q   (order_q)
  );

  burst_beat_ctr u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .beat_q   (beat_q),
    .at_first (burst_first),
    .at_last  (burst_last)
  );

  always_comb begin
    offset   = map_offset(order_q, start_q, beat_q);
    addr_out = {hi_q, offset};
    beat_idx = beat_q;
  end
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_evt,
  input logic              step_evt,
  input logic [ADDR_W-1:0] load_addr,
  input logic [ADDR_W-1:0] addr_out,
  input logic [1:0]        beat_idx,
  input logic              burst_first,
  input logic              burst_last
);
  // R2 and R6: a load restarts at beat 0 on the sampled address
  p_load_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (beat_idx == 2'd0) && (addr_out == $past(load_addr)));

  // R3 and R10: a step moves the beat on by one and wraps
  p_step_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> beat_idx == 2'($past(beat_idx) + 2'd1));

  // R7: with no event, nothing moves
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !step_evt) |=> ($stable(addr_out) && $stable(beat_idx)));

  // R8: the upper bits stay fixed unless a load happens
  p_upper_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(addr_out[ADDR_W-1:2]));

  // R11: the first and last flags never rise together
  p_flags_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({burst_first, burst_last}));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .load_evt    (load_evt),
  .step_evt    (step_evt),
  .load_addr   (load_addr),
  .addr_out    (addr_out),
  .beat_idx    (beat_idx),
  .burst_first (burst_first),
  .burst_last  (burst_last)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strobe_cpu = 1'b0, strobe_ctl = 1'b0, advance = 1'b0, order_sel = 1'b1;
  logic [AW-1:0] load_addr = '0;
  logic [AW-1:0] addr_out;
  logic [1:0]    beat_idx;
  logic          burst_first, burst_last;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
    .advance(advance), .order_sel(order_sel), .load_addr(load_addr),
    .addr_out(addr_out), .beat_idx(beat_idx),
    .burst_first(burst_first), .burst_last(burst_last)
  );

  typedef struct packed {
    logic          cpu;
    logic          ctl;
    logic          adv;
    logic          ord;
    logic [AW-1:0] ain;
    logic [AW-1:0] exp_a;
    logic [1:0]    exp_b;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 20'h12345, 20'h12345, 2'd0}, // R2 cpu load, linear
    '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h12346, 2'd1}, // R4
    '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h12347, 2'd2}, // R4
    '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h12344, 2'd3}, // R4 wrap of low bits
    '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'h12345, 2'd0}, // R10 back to start
    '{1'b0, 1'b0, 1'b0, 1'b1, 20'h77777, 20'h12345, 2'd0}, // R7 idle
    '{1'b0, 1'b1, 1'b0, 1'b1, 20'hABCDE, 20'hABCDE, 2'd0}, // R2 ctl load, interleaved
    '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'hABCDF, 2'd1}, // R5 R9 select changed
    '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'hABCDC, 2'd2}, // R5
    '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'hABCDD, 2'd3}, // R5
    '{1'b1, 1'b0, 1'b1, 1'b0, 20'h00003, 20'h00003, 2'd0}, // R6 strobe beats advance
    '{1'b0, 1'b0, 1'b1, 1'b1, 20'h00000, 20'h00000, 2'd1}, // R4 R8
    '{1'b1, 1'b1, 1'b1, 1'b1, 20'hFFFFF, 20'hFFFFF, 2'd0}, // R2 R6 both strobes
    '{1'b0, 1'b0, 1'b1, 1'b0, 20'h00000, 20'hFFFFE, 2'd1}, // R5
    '{1'b0, 1'b0, 1'b0, 1'b0, 20'h11111, 20'hFFFFE, 2'd1}  // R7 R8 idle
  };

  task automatic check(string tag, logic [AW-1:0] ea, logic [1:0] eb);
    logic ef, el;
    ef = (eb == 2'd0);
    el = (eb == 2'd3);
    total++;
    if (addr_out !== ea || beat_idx !== eb) begin
      bad++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, addr_out, beat_idx, ea, eb);
    end
    total++;
    if (burst_first !== ef || burst_last !== el) begin
      bad++;
      $display("FAIL R11 (%s): first=%b last=%b expected first=%b last=%b",
               tag, burst_first, burst_last, ef, el);
    end
  endtask

  task automatic drive(logic c, logic t, logic a, logic o, logic [AW-1:0] ad);
    @(negedge clk);
    strobe_cpu = c; strobe_ctl = t; advance = a; order_sel = o; load_addr = ad;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 in reset", '0, 2'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b1, 20'h5A5A5);
    check("R1 after reset", '0, 2'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].cpu, VECS[i].ctl, VECS[i].adv, VECS[i].ord, VECS[i].ain);
      check($sformatf("R2-table vec %0d", i), VECS[i].exp_a, VECS[i].exp_b);
    end

    // Every start offset in both orders, across one full wrap (R4 R5 R10)
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] base;
        base = {18'h2A5A5, 2'(s)};
        drive(1'b1, 1'b0, 1'b0, 1'(m), base);
        check(m ? "R5 load" : "R4 load", base, 2'd0);
        for (int k = 1; k <= 5; k++) begin
          logic [1:0] kb, sb, lo;
          kb = 2'(k % 4);
          sb = 2'(s);
          if (m == 0) lo = 2'((s + k) % 4);
          else lo = {sb[1] != kb[1], sb[0] != kb[0]};
          drive(1'b0, 1'b0, 1'b1, 1'(~m), '0);
          check(m ? "R5 R10 step" : "R4 R10 step", {18'h2A5A5, lo}, kb);
        end
      end
    end

    // Reset in the middle of a burst (R1)
    drive(1'b0, 1'b1, 1'b0, 1'b0, 20'h3C3C6);
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R4 before reset", 20'h3C3C7, 2'd1);
    @(negedge clk);
    advance = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 mid-burst reset", '0, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 1'b0, '0);
    check("R1 R3 step after reset", 20'h00001, 2'd1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule